// File: doc/BRIEF.md
# UART Automatic Hardware Flow Control

This block sits between a UART's receive FIFO, its transmit shifter and the two modem handshake pins. On the transmit side it gates every new character on the clear-to-send input. A two-flop synchronizer brings that input into the local clock domain. The shifter raises a ready signal when it is idle and has a character queued. The block answers with a start permit when the character may begin.

A CTS change never cuts short a character that has already begun. It only holds back the next start.

On the receive side the block drives the request-to-send output from the receive FIFO fill level. A hysteresis state machine compares the level against a halt threshold and a resume threshold. Each threshold comes from a 4-bit field counted in units of four characters. When a field is zero, a fallback value taken from the FIFO trigger level is used in its place.

Each function has its own enable. With automatic RTS off, the pin follows a host-written modem control bit. If RTS is looped back to CTS with both functions on, transmission stops whenever the receiving FIFO is too full, so the receiver cannot overrun.

Top module: `uart_hwflow`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `rts_n` is 1 (deasserted). With `auto_cts_en` = 1, `tx_start` is 0 until `cts_n` has been sampled low on two consecutive rising edges.
- R2: With `auto_cts_en` = 1, `tx_start` equals `tx_ready` when `cts_n` was low at the rising edge two edges earlier, and is 0 when it was high. A change of `cts_n` shows on `tx_start` after exactly two rising edges.
- R3: With `auto_cts_en` = 0, `tx_start` equals `tx_ready` in the same cycle, whatever the value of `cts_n`.
- R4: `tx_start` is never 1 while `tx_ready` is 0. A CTS deassertion therefore only withholds the next start and has no other effect.
- R5: With `auto_rts_en` = 1, a FIFO level at or above the halt level sets `rts_n` to 1 after the next rising edge. The halt level is `halt_fld`×4.
- R6: With `auto_rts_en` = 1 and RTS halted, a level at or below the resume level and below the halt level sets `rts_n` to 0 after the next rising edge. The resume level is `resume_fld`×4.
- R7: With `auto_rts_en` = 1, a level above the resume level and below the halt level leaves `rts_n` unchanged. A resume level at or above the halt level never overrides a halt.
- R8: A `halt_fld` of 0 makes the halt level equal `trig_lvl`. A `resume_fld` of 0 makes the resume level equal `trig_lvl`/2, rounded down. The two substitutions are independent.
- R9: With `auto_rts_en` = 0, `rts_n` equals the inverse of `mcr_rts` one rising edge later, whatever the FIFO level.
- R10: After `auto_rts_en` goes from 0 to 1, `rts_n` stays 1 until the level is at or below the resume level.
- R11: With both functions on and `rts_n` wired to `cts_n`, `tx_start` falls to 0 within three rising edges of the level reaching the halt level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| auto_cts_en | input | 1 | Enables CTS gating of transmit starts |
| auto_rts_en | input | 1 | Enables level-driven RTS |
| mcr_rts | input | 1 | Host RTS request, used when automatic RTS is off (1 = assert) |
| halt_fld | input | 4 | Halt threshold, in units of 4 characters; 0 selects the fallback |
| resume_fld | input | 4 | Resume threshold, in units of 4 characters; 0 selects the fallback |
| trig_lvl | input | 7 | FIFO trigger level used for the fallback thresholds |
| rx_level | input | 7 | Current receive FIFO fill level |
| cts_n | input | 1 | Clear-to-send pin, active low, asynchronous |
| tx_ready | input | 1 | Shifter idle with a character waiting |
| rts_n | output | 1 | Request-to-send pin, active low, registered |
| tx_start | output | 1 | Permit to start the next character |

## Verification
A corrupted hysteresis state appears on `rts_n` after one rising edge. It shows as a pin that deasserts inside the band between the thresholds, or one that fails to deassert at the halt level. A stuck or skipped synchronizer stage shows on `tx_start` as a permit that arrives one edge early or late after a CTS change. The bench pins that timing down to the exact edge. A fault in the threshold fallback appears only when a field is zero, so the stimulus moves the level across both the field-derived levels and the trigger-derived levels.

// File: rtl/flowctl_pkg.sv
package flowctl_pkg;

  typedef enum logic {
    RTS_FLOWING = 1'b0,
    RTS_HALTED  = 1'b1
  } rts_state_e;

  localparam int unsigned DEF_LVL_W   = 7;
  localparam int unsigned DEF_FLD_W   = 4;
  localparam int unsigned DEF_UNIT_SH = 2;
  localparam int unsigned DEF_SYNC_N  = 2;

endpackage

// File: rtl/flowctl_sync.sv
module flowctl_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);

  logic [STAGES-1:0] stage_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      logic d;
      if (g == 0) begin : g_first
        assign d = async_in;
      end else begin : g_chain
        assign d = stage_q[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= RST_VAL;
        else        stage_q[g] <= d;
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/flowctl_thresh.sv
module flowctl_thresh #(
  parameter int unsigned LVL_W   = 7,
  parameter int unsigned FLD_W   = 4,
  parameter int unsigned UNIT_SH = 2
) (
  input  logic [FLD_W-1:0] halt_fld,
  input  logic [FLD_W-1:0] resume_fld,
  input  logic [LVL_W-1:0] trig_lvl,
  output logic [LVL_W-1:0] halt_lvl,
  output logic [LVL_W-1:0] resume_lvl
);

  localparam int unsigned SCALED_W = FLD_W + UNIT_SH;

  logic [SCALED_W-1:0] halt_scaled;
  logic [SCALED_W-1:0] resume_scaled;
  logic [LVL_W-1:0]    trig_half;

  assign halt_scaled   = {halt_fld,   {UNIT_SH{1'b0}}};
  assign resume_scaled = {resume_fld, {UNIT_SH{1'b0}}};
  assign trig_half     = trig_lvl >> 1;

  // Each zero field falls back on its own; a non-zero field always wins.
  always_comb begin
    if (halt_fld == '0) halt_lvl = trig_lvl;
    else                halt_lvl = LVL_W'(halt_scaled);
    if (resume_fld == '0) resume_lvl = trig_half;
    else                  resume_lvl = LVL_W'(resume_scaled);
  end

endmodule

// File: rtl/flowctl_rts.sv
module flowctl_rts
  import flowctl_pkg::*;
#(
  parameter int unsigned LVL_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             auto_en,
  input  logic             host_rts,
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] halt_lvl,
  input  logic [LVL_W-1:0] resume_lvl,
  output logic             rts_n
);

  rts_state_e state_q, state_d;
  logic       rts_n_d;
  logic       at_halt;
  logic       at_resume;

  assign at_halt   = (level >= halt_lvl);
  // Resume only strictly below halt, so overlapping thresholds cannot oscillate.
  assign at_resume = (level <= resume_lvl) && !at_halt;

  always_comb begin
    state_d = state_q;
    if (!auto_en) begin
      state_d = RTS_HALTED;
    end else begin
      unique case (state_q)
        RTS_FLOWING: if (at_halt)   state_d = RTS_HALTED;
        RTS_HALTED:  if (at_resume) state_d = RTS_FLOWING;
        default:                    state_d = RTS_HALTED;
      endcase
    end
  end

  always_comb begin
    if (auto_en) rts_n_d = (state_d == RTS_HALTED);
    else         rts_n_d = !host_rts;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RTS_HALTED;
      rts_n   <= 1'b1;
    end else begin
      state_q <= state_d;
      rts_n   <= rts_n_d;
    end
  end

endmodule

// File: rtl/flowctl_cts.sv
module flowctl_cts (
  input  logic auto_en,
  input  logic cts_n_sync,
  input  logic tx_ready,
  output logic tx_start
);

  logic clear_to_send;

  // Only a new character start is gated; the shifter finishes what it began.
  assign clear_to_send = !auto_en || !cts_n_sync;
  assign tx_start      = tx_ready && clear_to_send;

endmodule

// File: rtl/uart_hwflow.sv
module uart_hwflow
  import flowctl_pkg::*;
#(
  parameter int unsigned LVL_W   = DEF_LVL_W,
  parameter int unsigned FLD_W   = DEF_FLD_W,
  parameter int unsigned UNIT_SH = DEF_UNIT_SH,
  parameter int unsigned SYNC_N  = DEF_SYNC_N
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             auto_cts_en,
  input  logic             auto_rts_en,
  input  logic             mcr_rts,
  input  logic [FLD_W-1:0] halt_fld,
  input  logic [FLD_W-1:0] resume_fld,
  input  logic [LVL_W-1:0] trig_lvl,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             cts_n,
  input  logic             tx_ready,
  output logic             rts_n,
  output logic             tx_start
);

  logic             cts_n_sync;
  logic [LVL_W-1:0] halt_lvl;
  logic [LVL_W-1:0] resume_lvl;

  flowctl_sync #(
    .STAGES (SYNC_N),
    .RST_VAL(1'b1)
  ) u_cts_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_in(cts_n),
    .sync_out(cts_n_sync)
  );

  flowctl_cts u_cts_gate (
    .auto_en   (auto_cts_en),
    .cts_n_sync(cts_n_sync),
    .tx_ready  (tx_ready),
    .tx_start  (tx_start)
  );

  flowctl_thresh #(
    .LVL_W  (LVL_W),
    .FLD_W  (FLD_W),
    .UNIT_SH(UNIT_SH)
  ) u_thresh (
    .halt_fld  (halt_fld),
    .resume_fld(resume_fld),
    .trig_lvl  (trig_lvl),
    .halt_lvl  (halt_lvl),
    .resume_lvl(resume_lvl)
  );

  flowctl_rts #(
    .LVL_W(LVL_W)
  ) u_rts (
    .clk       (clk),
    .rst_n     (rst_n),
    .auto_en   (auto_rts_en),
    .host_rts  (mcr_rts),
    .level     (rx_level),
    .halt_lvl  (halt_lvl),
    .resume_lvl(resume_lvl),
    .rts_n     (rts_n)
  );

endmodule

// File: rtl/uart_hwflow_chk.sv
module uart_hwflow_chk #(
  parameter int unsigned LVL_W   = 7,
  parameter int unsigned FLD_W   = 4,
  parameter int unsigned UNIT_SH = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             auto_cts_en,
  input logic             auto_rts_en,
  input logic             mcr_rts,
  input logic [FLD_W-1:0] halt_fld,
  input logic [FLD_W-1:0] resume_fld,
  input logic [LVL_W-1:0] rx_level,
  input logic             cts_n,
  input logic             tx_ready,
  input logic             rts_n,
  input logic             tx_start
);

  logic [LVL_W-1:0] halt4;
  logic [LVL_W-1:0] res4;
  logic             flds_set;

  assign halt4    = LVL_W'({halt_fld,   {UNIT_SH{1'b0}}});
  assign res4     = LVL_W'({resume_fld, {UNIT_SH{1'b0}}});
  assign flds_set = (halt_fld != '0) && (resume_fld != '0);

  // R9
  p_host_rts_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_rts_en |=> (rts_n == !$past(mcr_rts)));

  // R2
  p_cts_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_cts_en && $past(cts_n, 2)) |-> !tx_start);

  // R4
  p_start_needs_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> tx_ready);

  // R5
  p_halt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_rts_en && halt_fld != '0 && rx_level >= halt4) |=> rts_n);

  // R6
  p_resume_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_rts_en && flds_set && rx_level <= res4 && rx_level < halt4) |=> !rts_n);

  // R7
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_rts_en && $past(auto_rts_en) && flds_set &&
     rx_level > res4 && rx_level < halt4) |=> $stable(rts_n));

endmodule

bind uart_hwflow uart_hwflow_chk #(
  .LVL_W  (LVL_W),
  .FLD_W  (FLD_W),
  .UNIT_SH(UNIT_SH)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .auto_cts_en(auto_cts_en),
  .auto_rts_en(auto_rts_en),
  .mcr_rts    (mcr_rts),
  .halt_fld   (halt_fld),
  .resume_fld (resume_fld),
  .rx_level   (rx_level),
  .cts_n      (cts_n),
  .tx_ready   (tx_ready),
  .rts_n      (rts_n),
  .tx_start   (tx_start)
);

// File: tb/uart_hwflow_tb_top.sv
`timescale 1ns/1ps
module uart_hwflow_tb_top;

  logic       clk;
  logic       rst_n;
  logic       auto_cts_en;
  logic       auto_rts_en;
  logic       mcr_rts;
  logic [3:0] halt_fld;
  logic [3:0] resume_fld;
  logic [6:0] trig_lvl;
  logic [6:0] rx_level;
  logic       cts_manual;
  logic       loopback;
  logic       cts_n;
  logic       tx_ready;
  logic       rts_n;
  logic       tx_start;

  int n_cmp;
  int n_bad;
  bit done;

  assign cts_n = loopback ? rts_n : cts_manual;

  uart_hwflow dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .auto_cts_en(auto_cts_en),
    .auto_rts_en(auto_rts_en),
    .mcr_rts    (mcr_rts),
    .halt_fld   (halt_fld),
    .resume_fld (resume_fld),
    .trig_lvl   (trig_lvl),
    .rx_level   (rx_level),
    .cts_n      (cts_n),
    .tx_ready   (tx_ready),
    .rts_n      (rts_n),
    .tx_start   (tx_start)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // vector: {en[23], halt[22:19], resume[18:15], trig[14:8], level[7:1], exp_rts_n[0]}
  localparam int NV = 19;
  localparam logic [23:0] VEC [NV] = '{
    {1'b1, 4'd8, 4'd4, 7'd24, 7'd0,  1'b0},  // R10 resume from halted start
    {1'b1, 4'd8, 4'd4, 7'd24, 7'd20, 1'b0},  // R7 band, flowing
    {1'b1, 4'd8, 4'd4, 7'd24, 7'd31, 1'b0},  // R5 just below halt
    {1'b1, 4'd8, 4'd4, 7'd24, 7'd32, 1'b1},  // R5 halt level
    {1'b1, 4'd8, 4'd4, 7'd24, 7'd40, 1'b1},  // R5 above
    {1'b1, 4'd8, 4'd4, 7'd24, 7'd20, 1'b1},  // R7 band, halted
    {1'b1, 4'd8, 4'd4, 7'd24, 7'd17, 1'b1},  // R7 just above resume
    {1'b1, 4'd8, 4'd4, 7'd24, 7'd16, 1'b0},  // R6 resume level
    {1'b1, 4'd8, 4'd4, 7'd24, 7'd31, 1'b0},  // R7
    {1'b1, 4'd0, 4'd0, 7'd24, 7'd23, 1'b0},  // R8 fallback halt 24
    {1'b1, 4'd0, 4'd0, 7'd24, 7'd24, 1'b1},  // R8
    {1'b1, 4'd0, 4'd0, 7'd24, 7'd13, 1'b1},  // R8 fallback resume 12
    {1'b1, 4'd0, 4'd0, 7'd24, 7'd12, 1'b0},  // R8
    {1'b1, 4'd0, 4'd5, 7'd24, 7'd24, 1'b1},  // R8 halt from trig only
    {1'b1, 4'd0, 4'd5, 7'd24, 7'd20, 1'b0},  // R8 resume from field 20
    {1'b1, 4'd4, 4'd8, 7'd24, 7'd16, 1'b1},  // R7 overlap: halt wins
    {1'b1, 4'd4, 4'd8, 7'd24, 7'd10, 1'b0},  // R6 below both
    {1'b1, 4'd4, 4'd8, 7'd24, 7'd16, 1'b1},  // R5
    {1'b1, 4'd4, 4'd8, 7'd24, 7'd20, 1'b1}   // R7 no resume at/above halt
  };

  task automatic check(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #200000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    n_cmp = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0; auto_cts_en = 1'b1; auto_rts_en = 1'b0; mcr_rts = 1'b1;
    halt_fld = 4'd8; resume_fld = 4'd4; trig_lvl = 7'd24; rx_level = 7'd0;
    cts_manual = 1'b0; loopback = 1'b0; tx_ready = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 rts_n in reset", rts_n, 1'b1);
    check("R1 tx_start in reset", tx_start, 1'b0);
    rst_n = 1'b1;
    auto_rts_en = 1'b1;
    @(negedge clk);
    check("R1 tx_start one edge after reset", tx_start, 1'b0);

    // Table walk for the RTS thresholds
    for (int i = 0; i < NV; i++) begin
      auto_rts_en = VEC[i][23];
      halt_fld    = VEC[i][22:19];
      resume_fld  = VEC[i][18:15];
      trig_lvl    = VEC[i][14:8];
      rx_level    = VEC[i][7:1];
      @(negedge clk);
      check($sformatf("R5-R8 vector %0d", i), rts_n, VEC[i][0]);
    end

    // R9: host bit drives the pin
    auto_rts_en = 1'b0; rx_level = 7'd60; mcr_rts = 1'b1;
    @(negedge clk);
    check("R9 host assert", rts_n, 1'b0);
    mcr_rts = 1'b0;
    #1 check("R9 no same-cycle change", rts_n, 1'b0);
    @(negedge clk);
    check("R9 host deassert", rts_n, 1'b1);
    mcr_rts = 1'b1; rx_level = 7'd0;
    @(negedge clk);
    check("R9 level ignored", rts_n, 1'b0);

    // R10: re-enable inside the band
    halt_fld = 4'd8; resume_fld = 4'd4; rx_level = 7'd20; auto_rts_en = 1'b1;
    @(negedge clk);
    check("R10 deasserted on enable", rts_n, 1'b1);
    @(negedge clk);
    check("R10 still deasserted in band", rts_n, 1'b1);
    rx_level = 7'd10;
    @(negedge clk);
    check("R10 asserts at resume", rts_n, 1'b0);

    // R2: two-edge latency on CTS
    auto_cts_en = 1'b1; tx_ready = 1'b1; cts_manual = 1'b1;
    repeat (3) @(negedge clk);
    check("R2 blocked by high cts", tx_start, 1'b0);
    cts_manual = 1'b0;
    @(negedge clk);
    check("R2 still blocked after one edge", tx_start, 1'b0);
    @(negedge clk);
    check("R2 permit after two edges", tx_start, 1'b1);
    tx_ready = 1'b0;
    #1 check("R4 no start without ready", tx_start, 1'b0);
    tx_ready = 1'b1;
    cts_manual = 1'b1;
    @(negedge clk);
    check("R2 permit holds one edge", tx_start, 1'b1);
    @(negedge clk);
    check("R2 blocked two edges after deassert", tx_start, 1'b0);

    // R3: gating disabled
    auto_cts_en = 1'b0;
    #1 check("R3 cts ignored", tx_start, 1'b1);
    tx_ready = 1'b0;
    #1 check("R3 follows ready", tx_start, 1'b0);
    @(negedge clk);

    // R11: loopback
    auto_cts_en = 1'b1; tx_ready = 1'b1; loopback = 1'b1; rx_level = 7'd0;
    repeat (4) @(negedge clk);
    check("R11 loopback permits with room", tx_start, 1'b1);
    rx_level = 7'd32;
    repeat (2) @(negedge clk);
    check("R11 not yet blocked", tx_start, 1'b1);
    @(negedge clk);
    check("R11 blocked at halt", tx_start, 1'b0);

    finish_run();
  end

endmodule